// File: doc/BRIEF.md
# Video Memory Write Queue

This block sits between a host's data-port writes and the video memories of a display controller. Each host write carries a 16-bit value and a 4-bit access code. It takes its target address from an internal address register, which steps forward by a programmable increment after every accepted write. Writes wait in a four-entry ring. One entry at most is retired in each external access slot that the timing logic signals, and only after that entry's latency has run out. A retiring entry drives a one-cycle write strobe toward the pattern memory, the palette memory or the scroll memory.

The block also provides the two queue flags for the controller status word. It keeps the value held in the ring entry at the current write index, and a read from the narrow palette and scroll memories uses that value to fill the bits those memories do not store. A pending read takes an external slot in preference to the queue. When a slot has nothing ready to retire, the block flags it as unused.

Top module: `vmem_wfifo`

## Requirements
- R1: After reset the queue is empty, `status_word` reads 16'h3600, `wr_stall` is low and no strobe, `slot_unused` or `rd_serve` pulse is active.
- R2: The ring holds four entries and hands them out oldest first. A write offered while four entries are held raises `wr_stall` in the same cycle and is not taken, and this holds even if an entry retires in that cycle. A write is taken when `wr_valid` is high and the queue is not full.
- R3: A write taken at clock edge 0 can be retired by an `ext_slot` sampled at edge n only if n > 3·16 while `mode_wide` is 1 at acceptance, or only if n > 3·20 while it is 0.
- R4: An entry with code 4'b0001 retires over two slots. In the first, `vram_we` pulses with `mem_addr` equal to the stored address and `mem_data` = {8'h00, value[15:8]}, and the entry stays queued. In a later slot, `vram_we` pulses with `mem_addr` = stored address with bit 0 inverted and `mem_data` = {8'h00, value[7:0]}, and the entry is removed.
- R5: An entry with code 4'b0011 pulses `cram_we` and an entry with code 4'b0101 pulses `vsram_we`, each with `mem_data` equal to the full value, and each is removed in that one slot. Any other code is removed in one slot with no strobe.
- R6: A `rd_req` pulse sets a pending read. The next `ext_slot` clears it and pulses `rd_serve`, and no entry retires in that slot.
- R7: An `ext_slot` with no pending read, and either an empty queue or a head entry not yet due, pulses `slot_unused`.
- R8: `status_word` is 16'h3400, with bit 9 set when the queue is empty and bit 8 set when it is full.
- R9: `cram_rd_data` = (`cram_q` & 16'h0EEE) | (V & 16'hF111), where V is the value stored in the ring entry at the current write index, even if that entry has already retired.
- R10: `vsram_rd_data` = (`vsram_q` & 16'h03FF) | (V & 16'hF800), with V as in R9, so bit 10 reads 0.
- R11: An accepted write stores the current address register, which then advances by `autoinc`. `addr_load` loads `addr_val` at the next edge and takes priority over the advance. Every strobe and `rd_serve`/`slot_unused` pulse appears in the cycle after the `ext_slot` edge that caused it and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | 1: 16-clock slots, 0: 20-clock slots (sets the latency) |
| wr_valid | input | 1 | Host data-port write request |
| wr_data | input | 16 | Write value |
| wr_code | input | 4 | Access code of the write |
| wr_stall | output | 1 | Write refused because the queue is full |
| addr_load | input | 1 | Load the address register |
| addr_val | input | 16 | New address register value |
| autoinc | input | 8 | Address step after each accepted write |
| ext_slot | input | 1 | External access slot occurs this cycle |
| rd_req | input | 1 | Mark a memory read as pending |
| rd_serve | output | 1 | Slot given to the pending read |
| slot_unused | output | 1 | Slot had nothing to do |
| vram_we | output | 1 | Pattern memory byte write strobe |
| cram_we | output | 1 | Palette memory write strobe |
| vsram_we | output | 1 | Scroll memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 16 | Memory write data |
| status_word | output | 16 | Status word with queue flags |
| cram_q | input | 16 | Palette memory read value |
| vsram_q | input | 16 | Scroll memory read value |
| cram_rd_data | output | 16 | Palette read value with filled bits |
| vsram_rd_data | output | 16 | Scroll read value with filled bits |

## Verification
A lone write of each memory kind is followed by slots placed exactly on the latency boundary and one cycle past it, in both slot modes. This separates an off-by-one in the due timing from a wrong mode-dependent length. Four back-to-back writes with the host holding its request show whether the full flag and the stall line up, and whether the fifth value is kept rather than overwritten. A read request made while entries are due shows that the read wins the slot. A long random mix of codes, slot spacing, read requests, address loads and mode changes checks the wrap of both indices, the two-step pattern write interleaved with other entries, and the filled read bits, which follow whatever stale value sits at the write index.

// File: rtl/vwf_pkg.sv
package vwf_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    localparam logic [3:0] CODE_VRAM_WR  = 4'b0001;
    localparam logic [3:0] CODE_CRAM_WR  = 4'b0011;
    localparam logic [3:0] CODE_VSRAM_WR = 4'b0101;

    localparam logic [15:0] STATUS_BASE  = 16'h3400;
    localparam int          STAT_EMPTY_B = 9;
    localparam int          STAT_FULL_B  = 8;

    localparam logic [15:0] CRAM_KEEP    = 16'h0EEE;
    localparam logic [15:0] VSRAM_KEEP   = 16'h03FF;
    localparam logic [15:0] VSRAM_FILL   = 16'hF800;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        code;
    } vwf_entry_t;
endpackage

// File: rtl/vwf_due_timer.sv
module vwf_due_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          due
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign due = (cnt_q == '0);
endmodule

// File: rtl/vwf_read_fill.sv
module vwf_read_fill
    import vwf_pkg::*;
(
    input  logic [DATA_W-1:0] slot_value,
    input  logic [DATA_W-1:0] cram_q,
    input  logic [DATA_W-1:0] vsram_q,
    output logic [DATA_W-1:0] cram_rd_data,
    output logic [DATA_W-1:0] vsram_rd_data
);
    always_comb begin
        cram_rd_data  = (cram_q & CRAM_KEEP) | (slot_value & ~CRAM_KEEP);
        vsram_rd_data = (vsram_q & VSRAM_KEEP) | (slot_value & VSRAM_FILL);
    end
endmodule

// File: rtl/vwf_ring.sv
module vwf_ring
    import vwf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        wr_code,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic [7:0]        autoinc,
    input  logic              ext_slot,
    input  logic              rd_req,
    input  logic [DEPTH-1:0]  due,
    output logic              push,
    output logic [IW-1:0]     push_idx,
    output logic              empty,
    output logic              full,
    output logic [DATA_W-1:0] wr_slot_value,
    output logic              vram_we,
    output logic              cram_we,
    output logic              vsram_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              slot_unused,
    output logic              rd_serve
);
    typedef struct packed {
        logic [IW-1:0]                wr;
        logic [IW-1:0]                rd;
        logic                         empty;
        logic [DEPTH-1:0]             partial;
        logic                         pend;
        logic [ADDR_W-1:0]            addr;
        vwf_entry_t [DEPTH-1:0]       ent;
        logic                         vram_we;
        logic                         cram_we;
        logic                         vsram_we;
        logic                         unused;
        logic                         serve;
        logic [ADDR_W-1:0]            maddr;
        logic [DATA_W-1:0]            mdata;
    } ring_st_t;

    ring_st_t   st_d, st_q;
    logic       is_full;
    logic       accept;
    logic       pop;
    logic [IW-1:0] rd_inc;
    vwf_entry_t head;

    always_comb begin
        st_d          = st_q;
        st_d.vram_we  = 1'b0;
        st_d.cram_we  = 1'b0;
        st_d.vsram_we = 1'b0;
        st_d.unused   = 1'b0;
        st_d.serve    = 1'b0;
        st_d.maddr    = '0;
        st_d.mdata    = '0;

        is_full = !st_q.empty && (st_q.wr == st_q.rd);
        accept  = wr_valid && !is_full;
        pop     = 1'b0;
        rd_inc  = st_q.rd + IW'(1);
        head    = st_q.ent[st_q.rd];

        if (ext_slot) begin
            if (st_q.pend) begin
                st_d.pend  = 1'b0;
                st_d.serve = 1'b1;
            end else if (!st_q.empty && due[st_q.rd]) begin
                st_d.maddr = head.addr;
                st_d.mdata = head.value;
                case (head.code)
                    CODE_VRAM_WR: begin
                        st_d.vram_we = 1'b1;
                        if (!st_q.partial[st_q.rd]) begin
                            st_d.mdata               = {8'h00, head.value[15:8]};
                            st_d.partial[st_q.rd]    = 1'b1;
                        end else begin
                            st_d.maddr = head.addr ^ ADDR_W'(1);
                            st_d.mdata = {8'h00, head.value[7:0]};
                            pop        = 1'b1;
                        end
                    end
                    CODE_CRAM_WR: begin
                        st_d.cram_we = 1'b1;
                        pop          = 1'b1;
                    end
                    CODE_VSRAM_WR: begin
                        st_d.vsram_we = 1'b1;
                        pop           = 1'b1;
                    end
                    default: begin
                        st_d.maddr = '0;
                        st_d.mdata = '0;
                        pop        = 1'b1;
                    end
                endcase
            end else begin
                st_d.unused = 1'b1;
            end
        end

        if (rd_req) begin
            st_d.pend = 1'b1;
        end

        if (pop) begin
            st_d.rd = rd_inc;
        end

        if (accept) begin
            st_d.ent[st_q.wr].value = wr_data;
            st_d.ent[st_q.wr].addr  = st_q.addr;
            st_d.ent[st_q.wr].code  = wr_code;
            st_d.partial[st_q.wr]   = 1'b0;
            st_d.wr                 = st_q.wr + IW'(1);
            st_d.addr               = st_q.addr + ADDR_W'(autoinc);
            st_d.empty              = 1'b0;
        end else if (pop && (rd_inc == st_q.wr)) begin
            st_d.empty = 1'b1;
        end

        if (addr_load) begin
            st_d.addr = addr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign push          = accept;
    assign push_idx      = st_q.wr;
    assign empty         = st_q.empty;
    assign full          = is_full;
    assign wr_slot_value = st_q.ent[st_q.wr].value;
    assign vram_we       = st_q.vram_we;
    assign cram_we       = st_q.cram_we;
    assign vsram_we      = st_q.vsram_we;
    assign mem_addr      = st_q.maddr;
    assign mem_data      = st_q.mdata;
    assign slot_unused   = st_q.unused;
    assign rd_serve      = st_q.serve;
endmodule

// File: rtl/vmem_wfifo.sv
module vmem_wfifo
    import vwf_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int LAT_SLOTS   = 3,
    parameter int SLOT_WIDE   = 16,
    parameter int SLOT_NARROW = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wide,
    input  logic        wr_valid,
    input  logic [15:0] wr_data,
    input  logic [3:0]  wr_code,
    output logic        wr_stall,
    input  logic        addr_load,
    input  logic [15:0] addr_val,
    input  logic [7:0]  autoinc,
    input  logic        ext_slot,
    input  logic        rd_req,
    output logic        rd_serve,
    output logic        slot_unused,
    output logic        vram_we,
    output logic        cram_we,
    output logic        vsram_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_data,
    output logic [15:0] status_word,
    input  logic [15:0] cram_q,
    input  logic [15:0] vsram_q,
    output logic [15:0] cram_rd_data,
    output logic [15:0] vsram_rd_data
);
    localparam int IW         = $clog2(DEPTH);
    localparam int LAT_WIDE   = LAT_SLOTS * SLOT_WIDE;
    localparam int LAT_NARROW = LAT_SLOTS * SLOT_NARROW;
    localparam int LAT_MAX    = (LAT_WIDE > LAT_NARROW) ? LAT_WIDE : LAT_NARROW;
    localparam int TW         = $clog2(LAT_MAX + 1);

    logic              push;
    logic [IW-1:0]     push_idx;
    logic              q_empty;
    logic              q_full;
    logic [DEPTH-1:0]  due;
    logic [TW-1:0]     lat_val;
    logic [DATA_W-1:0] slot_value;

    assign lat_val = mode_wide ? TW'(LAT_WIDE) : TW'(LAT_NARROW);

    vwf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .wr_code       (wr_code),
        .addr_load     (addr_load),
        .addr_val      (addr_val),
        .autoinc       (autoinc),
        .ext_slot      (ext_slot),
        .rd_req        (rd_req),
        .due           (due),
        .push          (push),
        .push_idx      (push_idx),
        .empty         (q_empty),
        .full          (q_full),
        .wr_slot_value (slot_value),
        .vram_we       (vram_we),
        .cram_we       (cram_we),
        .vsram_we      (vsram_we),
        .mem_addr      (mem_addr),
        .mem_data      (mem_data),
        .slot_unused   (slot_unused),
        .rd_serve      (rd_serve)
    );

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_timer
        vwf_due_timer #(.TW(TW)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (push && (push_idx == IW'(gi))),
            .load_val (lat_val),
            .due      (due[gi])
        );
    end

    vwf_read_fill u_fill (
        .slot_value    (slot_value),
        .cram_q        (cram_q),
        .vsram_q       (vsram_q),
        .cram_rd_data  (cram_rd_data),
        .vsram_rd_data (vsram_rd_data)
    );

    always_comb begin
        status_word               = STATUS_BASE;
        status_word[STAT_EMPTY_B] = q_empty;
        status_word[STAT_FULL_B]  = q_full;
    end

    assign wr_stall = wr_valid && q_full;
endmodule

// File: rtl/vwf_checker.sv
module vwf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        wr_stall,
    input logic        ext_slot,
    input logic        rd_serve,
    input logic        slot_unused,
    input logic        vram_we,
    input logic        cram_we,
    input logic        vsram_we,
    input logic [15:0] status_word
);
    // R8: empty and full are never reported together
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_word[9] && status_word[8]));

    // R2: a write offered into a full queue is stalled
    a_r2_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && status_word[8]) |-> wr_stall);

    // R2: no stall while space remains
    a_r2_no_stall_with_room: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[8] |-> !wr_stall);

    // R7: one slot yields at most one outcome
    a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vram_we, cram_we, vsram_we, slot_unused, rd_serve}));

    // R11: every outcome pulse follows a slot by one cycle
    a_r11_outcome_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_we || cram_we || vsram_we || slot_unused || rd_serve) |-> $past(ext_slot));

    // R5: an empty queue writes nothing in the following cycle
    a_r5_empty_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[9] && ext_slot) |=> !(vram_we || cram_we || vsram_we));
endmodule

bind vmem_wfifo vwf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_stall    (wr_stall),
    .ext_slot    (ext_slot),
    .rd_serve    (rd_serve),
    .slot_unused (slot_unused),
    .vram_we     (vram_we),
    .cram_we     (cram_we),
    .vsram_we    (vsram_we),
    .status_word (status_word)
);

// File: tb/vmem_wfifo_tb.sv
module vmem_wfifo_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wide = 1'b1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  wr_code = '0;
    logic        wr_stall;
    logic        addr_load = 1'b0;
    logic [15:0] addr_val = '0;
    logic [7:0]  autoinc = '0;
    logic        ext_slot = 1'b0;
    logic        rd_req = 1'b0;
    logic        rd_serve, slot_unused, vram_we, cram_we, vsram_we;
    logic [15:0] mem_addr, mem_data, status_word;
    logic [15:0] cram_q = '0;
    logic [15:0] vsram_q = '0;
    logic [15:0] cram_rd_data, vsram_rd_data;

    always #10 clk = ~clk;

    vmem_wfifo u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_code(wr_code), .wr_stall(wr_stall),
        .addr_load(addr_load), .addr_val(addr_val), .autoinc(autoinc),
        .ext_slot(ext_slot), .rd_req(rd_req), .rd_serve(rd_serve), .slot_unused(slot_unused),
        .vram_we(vram_we), .cram_we(cram_we), .vsram_we(vsram_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .status_word(status_word),
        .cram_q(cram_q), .vsram_q(vsram_q),
        .cram_rd_data(cram_rd_data), .vsram_rd_data(vsram_rd_data)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // bench settings applied at drive time
    logic       drv_mode = 1'b1;
    logic [7:0] drv_inc = 8'd1;

    // reference model state
    logic [15:0] m_val [4];
    logic [15:0] m_addr [4];
    logic [3:0]  m_code [4];
    bit          m_part [4];
    int          m_stamp [4];
    int          m_lat [4];
    int          m_wr, m_rd, m_cnt, m_n;
    bit          m_pend, m_acc;
    logic [15:0] m_areg;
    logic        e_vram, e_cram, e_vsram, e_unused, e_serve;
    logic [15:0] e_maddr, e_mdata;

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_val[i] = '0; m_addr[i] = '0; m_code[i] = '0;
            m_part[i] = 0; m_stamp[i] = 0; m_lat[i] = 0;
        end
        m_wr = 0; m_rd = 0; m_cnt = 0; m_n = 0; m_pend = 0; m_acc = 0;
        m_areg = '0;
        e_vram = 0; e_cram = 0; e_vsram = 0; e_unused = 0; e_serve = 0;
        e_maddr = '0; e_mdata = '0;
    endtask

    task automatic model_step(input logic wv, input logic [15:0] wd, input logic [3:0] wc,
                              input logic sl, input logic rq, input logic aw, input logic [15:0] ain);
        bit acc, pop;
        int h;
        e_vram = 0; e_cram = 0; e_vsram = 0; e_unused = 0; e_serve = 0;
        e_maddr = '0; e_mdata = '0;
        acc = wv && (m_cnt < 4);
        pop = 0;
        if (sl) begin
            if (m_pend) begin
                m_pend = 0;
                e_serve = 1;
            end else if (m_cnt > 0 && (m_n - m_stamp[m_rd]) > m_lat[m_rd]) begin
                h = m_rd;
                e_maddr = m_addr[h];
                e_mdata = m_val[h];
                case (m_code[h])
                    4'd1: begin
                        e_vram = 1;
                        if (!m_part[h]) begin
                            e_mdata = {8'h00, m_val[h][15:8]};
                            m_part[h] = 1;
                        end else begin
                            e_maddr = m_addr[h] ^ 16'h0001;
                            e_mdata = {8'h00, m_val[h][7:0]};
                            pop = 1;
                        end
                    end
                    4'd3: begin e_cram = 1; pop = 1; end
                    4'd5: begin e_vsram = 1; pop = 1; end
                    default: begin e_maddr = '0; e_mdata = '0; pop = 1; end
                endcase
            end else begin
                e_unused = 1;
            end
        end
        if (rq) m_pend = 1;
        if (pop) begin
            m_rd = (m_rd + 1) % 4;
            m_cnt--;
        end
        if (acc) begin
            m_val[m_wr] = wd; m_addr[m_wr] = m_areg; m_code[m_wr] = wc;
            m_part[m_wr] = 0; m_stamp[m_wr] = m_n;
            m_lat[m_wr] = drv_mode ? 48 : 60;
            m_wr = (m_wr + 1) % 4;
            m_cnt++;
            m_areg = m_areg + {8'h00, drv_inc};
        end
        if (aw) m_areg = ain;
        m_acc = acc;
        m_n++;
    endtask

    // one clock: check last edge's outputs, drive, check combinational outputs, update model
    task automatic step(input logic wv, input logic [15:0] wd, input logic [3:0] wc,
                        input logic sl, input logic rq, input logic aw, input logic [15:0] ain);
        logic [15:0] sv;
        @(negedge clk);
        chk16("R4 vram_we", {15'd0, vram_we}, {15'd0, e_vram});
        chk16("R5 cram_we", {15'd0, cram_we}, {15'd0, e_cram});
        chk16("R5 vsram_we", {15'd0, vsram_we}, {15'd0, e_vsram});
        chk16("R7 slot_unused", {15'd0, slot_unused}, {15'd0, e_unused});
        chk16("R6 rd_serve", {15'd0, rd_serve}, {15'd0, e_serve});
        if (e_vram || e_cram || e_vsram) begin
            chk16("R11 mem_addr", mem_addr, e_maddr);
            chk16(e_vram ? "R4 mem_data" : "R5 mem_data", mem_data, e_mdata);
        end
        wr_valid = wv; wr_data = wd; wr_code = wc; ext_slot = sl; rd_req = rq;
        addr_load = aw; addr_val = ain; mode_wide = drv_mode; autoinc = drv_inc;
        cram_q = 16'($urandom); vsram_q = 16'($urandom);
        #1;
        sv = m_val[m_wr];
        chk16("R2 wr_stall", {15'd0, wr_stall}, {15'd0, wv && (m_cnt == 4)});
        chk16("R8 status_word", status_word,
              16'h3400 | ((m_cnt == 0) ? 16'h0200 : 16'h0) | ((m_cnt == 4) ? 16'h0100 : 16'h0));
        chk16("R9 cram_rd_data", cram_rd_data, (cram_q & 16'h0EEE) | (sv & 16'hF111));
        chk16("R10 vsram_rd_data", vsram_rd_data, (vsram_q & 16'h03FF) | (sv & 16'hF800));
        model_step(wv, wd, wc, sl, rq, aw, ain);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0, 0, 0, '0);
    endtask

    task automatic push_wait(input logic [15:0] wd, input logic [3:0] wc);
        m_acc = 0;
        while (!m_acc) step(1, wd, wc, 0, 0, 0, '0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk16("R1 status after reset", status_word, 16'h3600);
        chk16("R1 stall after reset", {15'd0, wr_stall}, 16'd0);
        chk16("R1 strobes after reset", {11'd0, vram_we, cram_we, vsram_we, slot_unused, rd_serve}, 16'd0);

        // R3 wide: latency boundary with a palette write
        drv_mode = 1; drv_inc = 8'd2;
        step(0, '0, '0, 0, 0, 1, 16'h1000);
        step(1, 16'h0ABC, 4'd3, 0, 0, 0, '0);
        idle(47);
        step(0, '0, '0, 1, 0, 0, '0);
        step(0, '0, '0, 1, 0, 0, '0);
        chk16("R3 wide slot at boundary unused", {15'd0, slot_unused}, 16'd1);
        idle(1);
        chk16("R3 wide slot past boundary retires", {15'd0, cram_we}, 16'd1);
        chk16("R11 palette address", mem_addr, 16'h1000);

        // R3 narrow: latency boundary with a scroll write
        drv_mode = 0;
        step(1, 16'hFFFF, 4'd5, 0, 0, 0, '0);
        idle(59);
        step(0, '0, '0, 1, 0, 0, '0);
        step(0, '0, '0, 1, 0, 0, '0);
        chk16("R3 narrow slot at boundary unused", {15'd0, slot_unused}, 16'd1);
        idle(1);
        chk16("R3 narrow slot past boundary retires", {15'd0, vsram_we}, 16'd1);
        chk16("R11 auto-increment address", mem_addr, 16'h1002);
        chk16("R10 fill after retire", vsram_rd_data, (vsram_q & 16'h03FF) | 16'h0000);

        // R4: pattern write in two slots
        drv_mode = 1;
        step(0, '0, '0, 0, 0, 1, 16'h2004);
        step(1, 16'hA55A, 4'd1, 0, 0, 0, '0);
        idle(50);
        step(0, '0, '0, 1, 0, 0, '0);
        idle(1);
        chk16("R4 high byte", mem_data, 16'h00A5);
        chk16("R4 high byte address", mem_addr, 16'h2004);
        step(0, '0, '0, 1, 0, 0, '0);
        idle(1);
        chk16("R4 low byte", mem_data, 16'h005A);
        chk16("R4 low byte address", mem_addr, 16'h2005);

        // R2: fill to four and stall the fifth
        push_wait(16'h1111, 4'd3);
        push_wait(16'h2222, 4'd1);
        push_wait(16'h3333, 4'd0);
        push_wait(16'h4444, 4'd5);
        step(1, 16'h5555, 4'd3, 0, 0, 0, '0);
        chk16("R2 stall when full", {15'd0, wr_stall}, 16'd1);
        chk16("R8 full flag", status_word, 16'h3500);
        idle(50);
        // R6: pending read takes the first slot
        step(0, '0, '0, 0, 1, 0, '0);
        step(0, '0, '0, 1, 0, 0, '0);
        idle(1);
        chk16("R6 read served first", {15'd0, rd_serve}, 16'd1);
        for (int i = 0; i < 10; i++) step(0, '0, '0, 1, 0, 0, '0);
        push_wait(16'h5555, 4'd3);
        for (int i = 0; i < 70; i++) step(0, '0, '0, 1, 0, 0, '0);
        chk16("R8 empty after drain", status_word, 16'h3600);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] c;
            if (i % 500 == 0) begin
                drv_mode = 1'($urandom);
                drv_inc = 8'($urandom % 4);
            end
            case ($urandom % 5)
                0: c = 4'd1; 1: c = 4'd3; 2: c = 4'd5; 3: c = 4'd1; default: c = 4'($urandom);
            endcase
            step(($urandom % 3) == 0, 16'($urandom), c, ($urandom % 4) == 0,
                 ($urandom % 16) == 0, ($urandom % 32) == 0, 16'($urandom));
        end
        idle(2);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule